// File: doc/BRIEF.md
# Distributed Round-Robin Bus Arbitration Agent

This block is one participant in a shared bus that has no central arbiter. The bus carries one active-low request line per agent, with two or four agents. Each agent drives its own copy of the request vector, and the board combines all copies as a wired-AND. The agent reads the combined vector back. While reset is held, a separate strap driver pulls one line low in each agent's view. The agent takes the index of that line as its identity, so each agent learns a different ID on every reset without any configuration.

After reset the agent requests the bus only on the line whose index is its own ID. It keeps a private register holding the current owner and updates it from the combined lines with a rule shared by every agent. Because all agents see the same lines and apply the same rule, their owner registers always agree. A local client raises a level request and receives a grant once the tracked owner is this agent. The strap driver moves its line assignment on by one position at every reset release, so the agent that held ID 0 gets a different ID after the next reset.

The request sequencer is a three-state machine:
- ST_IDLE: the agent is not requesting. It moves to ST_REQ when the local request is high.
- ST_REQ: the agent is requesting and is not yet the owner. It moves to ST_OWN when it wins, or back to ST_IDLE if the local request drops.
- ST_OWN: the agent holds the bus. It moves to ST_IDLE when the local request drops.

Top module: `rr_bus_agent`

## Requirements
- R1: While reset is low, the agent samples its request-line view on every clock edge. After release, `agent_id_o` equals the index of the line that was low at the last sampling edge. If several lines were low, the lowest index wins.
- R2: The agent drives at most one line low, and that line is bit `agent_id_o`. It drives it low exactly when the sequencer is in ST_REQ or ST_OWN. All lines are high in ST_IDLE and during reset.
- R3: During reset the tracked owner `owner_o` equals N-1, and no grant is active.
- R4: When the owner's line is high and at least one line is low, the next owner is the first low line found by scanning indices owner+1, owner+2, … modulo N. The register updates on the following edge, and all agents hold identical `owner_o` values.
- R5: While the owner's line is low, `owner_o` does not change.
- R6: When every line is high, `owner_o` keeps its last value.
- R7: `loc_gnt_o` is high exactly when the sequencer is in ST_REQ or ST_OWN, `owner_o` equals `agent_id_o`, and line `agent_id_o` is low. Across all agents, at most one grant is high.
- R8: The sequencer follows these transitions: ST_IDLE→ST_REQ on a high local request; ST_REQ→ST_OWN on a win; ST_REQ→ST_IDLE and ST_OWN→ST_IDLE on a low local request. The drive line follows the local request with one cycle of delay.
- R9: During reset, the strap driver gives agent a a view in which only line (a+k) mod N is low, where k counts the reset releases since power-on. Outside reset, every view equals the combined bus. With N=2, the IDs swap on every reset.
- R10: `agent_id_o` stays constant while reset is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. The ID is sampled while it is low |
| req_bus_n_i | input | N | Observed request lines (wired-AND, or strap view during reset) |
| req_drv_n_o | output | N | This agent's drive onto the request lines, active low |
| loc_req_i | input | 1 | Local client level request |
| loc_gnt_o | output | 1 | Local grant |
| agent_id_o | output | $clog2(N) | ID captured at reset |
| owner_o | output | $clog2(N) | Tracked current bus owner |

## Verification
A wrong owner register in one agent appears one clock after the faulty update. Its `owner_o` then differs from its peers, and the next request can produce either two grants or none. A wrongly captured ID shows right after reset release. The agent then drives the wrong line, or the same line as a peer, as soon as it requests. A sequencer fault shows on `req_drv_n_o` one cycle after the local request changes.

// File: rtl/rr_arb_pkg.sv
package rr_arb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_OWN  = 2'd2
    } agent_state_e;
endpackage

// File: rtl/rr_id_capture.sv
module rr_id_capture #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   lines_n_i,
    output logic [IDW-1:0] id_o
);
    logic [IDW-1:0] id_q;
    logic [IDW-1:0] pick;
    logic           seen;

    // lowest low line wins: scan downward so the last hit is the lowest index
    always_comb begin
        pick = id_q;
        seen = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (!lines_n_i[i]) begin
                pick = IDW'(i);
                seen = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n && seen) begin
            id_q <= pick;
        end
    end

    assign id_o = id_q;
endmodule

// File: rtl/rr_owner_track.sv
module rr_owner_track #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   lines_n_i,
    output logic [IDW-1:0] owner_o
);
    localparam logic [IDW-1:0] OWNER_INIT = IDW'(N - 1);

    logic [IDW-1:0] owner_q;
    logic [IDW-1:0] owner_d;
    logic           found;

    always_comb begin
        owner_d = owner_q;
        found   = 1'b0;
        if (lines_n_i[owner_q]) begin
            for (int k = 1; k < N; k++) begin
                if (!found && !lines_n_i[(int'(owner_q) + k) % N]) begin
                    owner_d = IDW'((int'(owner_q) + k) % N);
                    found   = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            owner_q <= OWNER_INIT;
        end else begin
            owner_q <= owner_d;
        end
    end

    assign owner_o = owner_q;
endmodule

// File: rtl/rr_req_fsm.sv
module rr_req_fsm
    import rr_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic loc_req_i,
    input  logic win_i,
    output logic drive_act_o,
    output logic gnt_o
);
    agent_state_e state_q;
    agent_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (loc_req_i) state_d = ST_REQ;
            ST_REQ: begin
                if (!loc_req_i)  state_d = ST_IDLE;
                else if (win_i)  state_d = ST_OWN;
            end
            ST_OWN:  if (!loc_req_i) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        drive_act_o = 1'b0;
        gnt_o       = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_REQ: begin
                drive_act_o = 1'b1;
                gnt_o       = win_i;
            end
            ST_OWN: begin
                drive_act_o = 1'b1;
                gnt_o       = win_i;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/rr_strap_driver.sv
module rr_strap_driver #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           por_n,
    input  logic           rst_n,
    input  logic [N-1:0]   bus_n_i,
    output logic [N*N-1:0] view_n_o
);
    logic [IDW-1:0] rot_q;
    logic           rst_d;

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            rot_q <= '0;
            rst_d <= 1'b0;
        end else begin
            rst_d <= rst_n;
            if (rst_n && !rst_d) begin
                rot_q <= IDW'((int'(rot_q) + 1) % N);
            end
        end
    end

    for (genvar ga = 0; ga < N; ga++) begin : g_agent
        for (genvar gl = 0; gl < N; gl++) begin : g_line
            assign view_n_o[ga*N + gl] = rst_n ? bus_n_i[gl]
                : (IDW'((ga + int'(rot_q)) % N) != IDW'(gl));
        end
    end
endmodule

// File: rtl/rr_bus_agent.sv
module rr_bus_agent #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req_bus_n_i,
    output logic [N-1:0]   req_drv_n_o,
    input  logic           loc_req_i,
    output logic           loc_gnt_o,
    output logic [IDW-1:0] agent_id_o,
    output logic [IDW-1:0] owner_o
);
    logic [IDW-1:0] my_id;
    logic [IDW-1:0] owner;
    logic           win;
    logic           drive_act;

    rr_id_capture #(.N(N), .IDW(IDW)) u_id (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_n_i (req_bus_n_i),
        .id_o      (my_id)
    );

    rr_owner_track #(.N(N), .IDW(IDW)) u_own (
        .clk       (clk),
        .rst_n     (rst_n),
        .lines_n_i (req_bus_n_i),
        .owner_o   (owner)
    );

    assign win = (owner == my_id) && !req_bus_n_i[my_id];

    rr_req_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .loc_req_i   (loc_req_i),
        .win_i       (win),
        .drive_act_o (drive_act),
        .gnt_o       (loc_gnt_o)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_drv
        assign req_drv_n_o[gi] = !(drive_act && (my_id == IDW'(gi)));
    end

    assign agent_id_o = my_id;
    assign owner_o    = owner;
endmodule

// File: rtl/rr_agent_chk.sv
module rr_agent_chk #(
    parameter int N   = 4,
    parameter int IDW = $clog2(N)
) (
    input logic           clk,
    input logic           rst_n,
    input logic [N-1:0]   req_bus_n_i,
    input logic [N-1:0]   req_drv_n_o,
    input logic           loc_req_i,
    input logic           loc_gnt_o,
    input logic [IDW-1:0] agent_id_o,
    input logic [IDW-1:0] owner_o
);
    logic [N-1:0] bus_d;
    always_ff @(posedge clk) bus_d <= req_bus_n_i;

    // R2
    drv_single_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~req_drv_n_o) <= 1);
    // R2
    drv_own_index_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_drv_n_o != {N{1'b1}}) |-> !req_drv_n_o[agent_id_o]);
    // R7
    gnt_owner_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        loc_gnt_o |-> (owner_o == agent_id_o && !req_bus_n_i[agent_id_o]));
    // R5
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_bus_n_i[owner_o] |=> $stable(owner_o));
    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&req_bus_n_i) |=> $stable(owner_o));
    // R4
    owner_to_requester_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(owner_o) |-> !bus_d[owner_o]);
    // R8
    drop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loc_req_i |=> (&req_drv_n_o));
    // R10
    id_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(agent_id_o));
endmodule

bind rr_bus_agent rr_agent_chk #(.N(N), .IDW(IDW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_bus_n_i (req_bus_n_i),
    .req_drv_n_o (req_drv_n_o),
    .loc_req_i   (loc_req_i),
    .loc_gnt_o   (loc_gnt_o),
    .agent_id_o  (agent_id_o),
    .owner_o     (owner_o)
);

// File: tb/tb_rr_bus_agent.sv
`timescale 1ns/1ps
module tb_rr_bus_agent;
    localparam int N   = 4;
    localparam int IDW = $clog2(N);

    logic clk   = 1'b0;
    logic por_n = 1'b0;
    logic rst_n = 1'b0;
    logic [N-1:0]   loc_req = '0;
    logic [N-1:0]   drv_n [N];
    logic [N-1:0]   bus_n;
    logic [N*N-1:0] view_n;
    logic [IDW-1:0] id_w  [N];
    logic [IDW-1:0] own_w [N];
    logic [N-1:0]   gnt_w;

    int n_chk  = 0;
    int n_fail = 0;
    int rel_k  = 0;
    int cur_k  = 0;
    logic [N-1:0]   exp_act   = '0;
    logic [IDW-1:0] exp_owner = IDW'(N - 1);

    always #2 clk = ~clk;

    always_comb begin
        bus_n = '1;
        for (int a = 0; a < N; a++) bus_n = bus_n & drv_n[a];
    end

    rr_strap_driver #(.N(N)) u_strap (
        .clk (clk), .por_n (por_n), .rst_n (rst_n),
        .bus_n_i (bus_n), .view_n_o (view_n)
    );

    for (genvar gi = 0; gi < N; gi++) begin : g_ag
        rr_bus_agent #(.N(N)) dut (
            .clk         (clk),
            .rst_n       (rst_n),
            .req_bus_n_i (view_n[gi*N +: N]),
            .req_drv_n_o (drv_n[gi]),
            .loc_req_i   (loc_req[gi]),
            .loc_gnt_o   (gnt_w[gi]),
            .agent_id_o  (id_w[gi]),
            .owner_o     (own_w[gi])
        );
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [IDW-1:0] f_id(input int a);
        return IDW'((a + cur_k) % N);
    endfunction

    function automatic logic [N-1:0] f_drv(input int a);
        logic [N-1:0] v = '1;
        if (exp_act[a]) v[f_id(a)] = 1'b0;
        return v;
    endfunction

    function automatic logic [N-1:0] f_bus();
        logic [N-1:0] v = '1;
        for (int a = 0; a < N; a++) v = v & f_drv(a);
        return v;
    endfunction

    function automatic logic [IDW-1:0] f_next(input logic [IDW-1:0] o, input logic [N-1:0] b);
        if (!b[o]) return o;
        for (int k = 1; k < N; k++) begin
            if (!b[(int'(o) + k) % N]) return IDW'((int'(o) + k) % N);
        end
        return o;
    endfunction

    task automatic step(input logic [N-1:0] nreq);
        logic [N-1:0] eb;
        @(negedge clk);
        eb = f_bus();
        for (int a = 0; a < N; a++) begin
            logic eg;
            eg = exp_act[a] && (exp_owner == f_id(a)) && !eb[f_id(a)];
            chk(id_w[a] == f_id(a), "R1 captured id", int'(id_w[a]), int'(f_id(a)));
            chk(drv_n[a] == f_drv(a), "R2/R8 drive lines", int'(drv_n[a]), int'(f_drv(a)));
            chk(own_w[a] == exp_owner, "R4/R5/R6 tracked owner", int'(own_w[a]), int'(exp_owner));
            chk(gnt_w[a] == eg, "R7 grant", int'(gnt_w[a]), int'(eg));
        end
        chk($countones(gnt_w) <= 1, "R7 single grant", $countones(gnt_w), 1);
        loc_req   = nreq;
        exp_owner = f_next(exp_owner, eb);
        exp_act   = nreq;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n   = 1'b0;
        loc_req = '0;
        repeat (3) @(negedge clk);
        for (int a = 0; a < N; a++) begin
            logic [N-1:0] ev = '1;
            ev[(a + rel_k) % N] = 1'b0;
            chk(view_n[a*N +: N] == ev, "R9 strap view", int'(view_n[a*N +: N]), int'(ev));
            chk(own_w[a] == IDW'(N - 1), "R3 owner in reset", int'(own_w[a]), N - 1);
            chk(gnt_w[a] == 1'b0, "R3 grant in reset", int'(gnt_w[a]), 0);
            chk(drv_n[a] == '1, "R2 drive in reset", int'(drv_n[a]), (1 << N) - 1);
        end
        rst_n     = 1'b1;
        cur_k     = rel_k;
        rel_k     = rel_k + 1;
        exp_act   = '0;
        exp_owner = IDW'(N - 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        logic [N-1:0] r;
        void'($urandom(32'd1234));
        repeat (2) @(negedge clk);
        por_n = 1'b1;
        do_reset();
        // directed, IDs equal agent index here: R3 start at N-1, R4 scan picks 0 over 2
        step(4'b0000);
        step(4'b0101);
        step(4'b0101);
        step(4'b0101);
        step(4'b0100);   // owner 0 drops: R4 moves to 2
        step(4'b0100);
        step(4'b0000);   // R6 idle keeps owner 2
        step(4'b0000);
        step(4'b1010);   // from 2, scan finds 3 before 1
        step(4'b1010);
        step(4'b0010);
        step(4'b0010);
        step(4'b0000);
        // random epochs, each after a fresh reset (R9/R1 rotation)
        for (int e = 0; e < 5; e++) begin
            if (e > 0) do_reset();
            r = '0;
            for (int c = 0; c < 300; c++) begin
                for (int a = 0; a < N; a++) begin
                    if ($urandom_range(4) == 0) r[a] = ~r[a];
                end
                step(r);
            end
            step('0);
            step('0);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule